// File: doc/BRIEF.md
# Tearing-Effect Start Trigger

This block decides when a frame transfer toward a panel may begin, so that new pixel data does not overtake the panel's own scan and tear the picture. The panel reports its scan position through one or two tearing-effect lines. The block measures how long each pulse stays active, in functional-clock cycles, and sorts it into a vertical (frame) or horizontal (line) event. After a vertical event it counts horizontal events. It emits a single-cycle start pulse toward the pixel transfer engine when the count reaches a programmed line number.

Three trigger modes exist. In internal mode a software request starts the transfer at once, with no reference to the panel. In shared-line mode a single input carries both pulse kinds, which differ only in length. In split-line mode, separate vertical and horizontal inputs are each qualified by their own minimum width. Each line has its own polarity bit. A set of consistency rules on the programmed widths is checked continuously, and while those rules are broken a request in a synchronised mode is refused.

Top module: `te_trigger_top`

## Requirements
- R1: After reset, `start` is 0, `armed` is 0 and `line_cnt` is 0.
- R2: With `mode` equal to 0 (internal) or 3 (treated as internal), a one-cycle `go` makes `start` high for exactly the next cycle, and `armed` stays 0. A `go` in the cycle where `start` is already high is ignored.
- R3: With `mode` 1 (shared line) or 2 (split lines) and a valid configuration, `go` sets `armed` in the next cycle, and no `start` follows until the line target is met.
- R4: `cfg_err` is 1 when, in mode 1, `hs_width` < 2, `vs_width` < 4 or `vs_width` <= `hs_width`; or when, in mode 2, `hs_width` < 2, `vs_width` < 2 or the two widths are equal. It is 0 in modes 0 and 3. A `go` in mode 1 or 2 while `cfg_err` is 1 leaves `armed` at 0.
- R5: Pulse length is the number of clock cycles the line spends at its active level. A polarity bit of 1 means active-high and 0 means active-low. `vs_pol` governs `te_in` and `hs_pol` governs `te_hs_in`.
- R6: In mode 1, a `te_in` pulse of length >= `vs_width` is vertical. A pulse with `hs_width` <= length < `vs_width` is horizontal. A shorter pulse is ignored.
- R7: In mode 2, a `te_in` pulse is vertical when its length is >= `vs_width` and is otherwise ignored. A `te_hs_in` pulse is horizontal when its length is >= `hs_width`, whatever its length above that. When both end in the same cycle, only the vertical event counts.
- R8: While armed, a vertical event sets `line_cnt` to 0 and each later horizontal event adds 1. Horizontal events before the first vertical event of an armed transfer are ignored. While not armed, `line_cnt` holds its value.
- R9: `start` fires for one cycle when the count equals `line_num` (11 bits, 0 to 2047). A value of 0 fires on the vertical event itself. `armed` then drops, and later pulses give no further start.
- R10: A vertical event arriving before the target line restarts the count from 0.
- R11: A `go` while armed has no effect: `armed` stays 1 and `line_cnt` is unchanged.
- R12: The pulse-length counter saturates at its maximum instead of wrapping, so an overlong pulse still classifies as vertical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 internal, 1 shared line, 2 split lines, 3 internal |
| hs_width | input | WIDTH_W | Minimum horizontal pulse length in cycles |
| vs_width | input | WIDTH_W | Minimum vertical pulse length in cycles |
| line_num | input | LINE_W | Line index at which the start fires |
| hs_pol | input | 1 | 1: `te_hs_in` active-high |
| vs_pol | input | 1 | 1: `te_in` active-high |
| te_in | input | 1 | Shared tearing-effect line, or vertical line in mode 2 |
| te_hs_in | input | 1 | Horizontal line in mode 2 |
| go | input | 1 | Software transfer request |
| start | output | 1 | One-cycle transfer start pulse |
| armed | output | 1 | A request waits for its line |
| cfg_err | output | 1 | Programmed widths are inconsistent for the mode |
| line_cnt | output | LINE_W | Lines counted since the last vertical event |

## Verification
The bench drives pulses one cycle either side of each width threshold, so a design that compares with the wrong inequality turns a line pulse into a frame pulse, or drops one. It sends horizontal pulses before any vertical pulse, a second vertical pulse in mid-count, a repeated request and a zero line target. A design that counted too early, failed to restart, re-armed or missed the immediate fire would show the wrong count or a missing or extra start. A 260-cycle pulse exposes a wrapping length counter, which would call the pulse horizontal. Coincident split-line pulses expose a design that counts both events. Seeded random pulse trains in shared-line mode are checked against a reference model of the counting rules.

// File: rtl/te_trig_pkg.sv
`timescale 1ns/1ps
package te_trig_pkg;

   typedef enum logic [1:0] {
      TRIG_INTERNAL = 2'd0,
      TRIG_SHARED   = 2'd1,
      TRIG_SPLIT    = 2'd2,
      TRIG_RSVD     = 2'd3
   } trig_mode_e;

   typedef enum logic [1:0] {
      TRK_IDLE   = 2'd0,
      TRK_WAIT_V = 2'd1,
      TRK_COUNT  = 2'd2
   } trk_state_e;

   localparam int MIN_HS_TICKS        = 2;
   localparam int MIN_VS_TICKS_SHARED = 4;
   localparam int MIN_VS_TICKS_SPLIT  = 2;
   localparam int NUM_TE_CHANNELS     = 2;

endpackage

// File: rtl/te_pulse_meter.sv
`timescale 1ns/1ps
module te_pulse_meter #(
   parameter int WIDTH_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_i,
   input  logic               act_high_i,
   output logic               end_o,
   output logic [WIDTH_W-1:0] len_o
);

   localparam logic [WIDTH_W-1:0] LEN_MAX = '1;
   localparam logic [WIDTH_W-1:0] LEN_ONE = WIDTH_W'(1);

   logic line_s;
   logic active;
   logic act_q;
   logic [WIDTH_W-1:0] cnt_q;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign line_s = line_i;
   end else if (SYNC_STAGES == 1) begin : g_sync1
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= 1'b0;
         else        sync_q <= line_i;
      end
      assign line_s = sync_q;
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      end
      assign line_s = sync_q[SYNC_STAGES-1];
   end

   assign active = act_high_i ? line_s : ~line_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
         end_o <= 1'b0;
         len_o <= '0;
      end else begin
         act_q <= active;
         end_o <= act_q & ~active;
         if (act_q & ~active) len_o <= cnt_q;
         if (active) begin
            if (!act_q)                cnt_q <= LEN_ONE;
            else if (cnt_q != LEN_MAX) cnt_q <= cnt_q + LEN_ONE;
         end
      end
   end

   AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      end_o |-> (len_o != '0)); // R5
   AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      end_o |=> !end_o); // R5
   AST_LEN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && $past(act_q) && $past(cnt_q) == LEN_MAX) |-> (cnt_q == LEN_MAX)); // R12

endmodule

// File: rtl/te_event_class.sv
`timescale 1ns/1ps
module te_event_class
   import te_trig_pkg::*;
#(
   parameter int WIDTH_W = 8
) (
   input  trig_mode_e         mode_i,
   input  logic [WIDTH_W-1:0] hs_width_i,
   input  logic [WIDTH_W-1:0] vs_width_i,
   input  logic               a_end_i,
   input  logic [WIDTH_W-1:0] a_len_i,
   input  logic               b_end_i,
   input  logic [WIDTH_W-1:0] b_len_i,
   output logic               v_evt_o,
   output logic               h_evt_o,
   output logic               cfg_err_o
);

   localparam logic [WIDTH_W-1:0] HS_MIN   = WIDTH_W'(MIN_HS_TICKS);
   localparam logic [WIDTH_W-1:0] VS_MIN_A = WIDTH_W'(MIN_VS_TICKS_SHARED);
   localparam logic [WIDTH_W-1:0] VS_MIN_B = WIDTH_W'(MIN_VS_TICKS_SPLIT);

   logic a_is_v;
   logic a_is_h;
   logic b_is_h;

   assign a_is_v = a_end_i && (a_len_i >= vs_width_i);
   assign a_is_h = a_end_i && (a_len_i >= hs_width_i) && (a_len_i < vs_width_i);
   assign b_is_h = b_end_i && (b_len_i >= hs_width_i);

   always_comb begin
      cfg_err_o = 1'b0;
      v_evt_o   = 1'b0;
      h_evt_o   = 1'b0;
      unique case (mode_i)
         TRIG_SHARED: begin
            cfg_err_o = (hs_width_i < HS_MIN) || (vs_width_i < VS_MIN_A) ||
                        (vs_width_i <= hs_width_i);
            v_evt_o   = a_is_v;
            h_evt_o   = a_is_h;
         end
         TRIG_SPLIT: begin
            cfg_err_o = (hs_width_i < HS_MIN) || (vs_width_i < VS_MIN_B) ||
                        (vs_width_i == hs_width_i);
            v_evt_o   = a_is_v;
            h_evt_o   = b_is_h && !a_is_v;
         end
         default: begin
            cfg_err_o = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/te_line_tracker.sv
`timescale 1ns/1ps
module te_line_tracker
   import te_trig_pkg::*;
#(
   parameter int LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              internal_i,
   input  logic              cfg_err_i,
   input  logic              go_i,
   input  logic              v_evt_i,
   input  logic              h_evt_i,
   input  logic [LINE_W-1:0] line_num_i,
   output logic              start_o,
   output logic              armed_o,
   output logic [LINE_W-1:0] line_cnt_o
);

   trk_state_e state_q;
   logic [LINE_W-1:0] cnt_q;
   logic [LINE_W-1:0] cnt_nxt;
   logic start_q;

   assign cnt_nxt    = cnt_q + LINE_W'(1);
   assign start_o    = start_q;
   assign armed_o    = (state_q != TRK_IDLE);
   assign line_cnt_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TRK_IDLE;
         cnt_q   <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         unique case (state_q)
            TRK_IDLE: begin
               if (go_i) begin
                  if (internal_i) begin
                     if (!start_q) start_q <= 1'b1;
                  end else if (!cfg_err_i) begin
                     state_q <= TRK_WAIT_V;
                  end
               end
            end
            default: begin
               if (v_evt_i) begin
                  cnt_q <= '0;
                  if (line_num_i == '0) begin
                     start_q <= 1'b1;
                     state_q <= TRK_IDLE;
                  end else begin
                     state_q <= TRK_COUNT;
                  end
               end else if (h_evt_i && state_q == TRK_COUNT) begin
                  cnt_q <= cnt_nxt;
                  if (cnt_nxt == line_num_i) begin
                     start_q <= 1'b1;
                     state_q <= TRK_IDLE;
                  end
               end
            end
         endcase
      end
   end

   AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(v_evt_i && h_evt_i)); // R7
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o); // R9
   AST_DISARM_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> !armed_o); // R9
   AST_LINE_ZERO_AFTER_V: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_o && v_evt_i) |=> (line_cnt_o == '0)); // R8
   AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TRK_COUNT && h_evt_i) |=> (line_cnt_o == $past(line_cnt_o) + LINE_W'(1))); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_o |=> $stable(line_cnt_o)); // R8
   AST_CFG_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_o && go_i && cfg_err_i && !internal_i) |=> !armed_o); // R4
   AST_INTERNAL_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_o && internal_i) |=> !armed_o); // R2
   AST_GO_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_o && go_i && !v_evt_i && !h_evt_i) |=> (armed_o && $stable(line_cnt_o))); // R11

endmodule

// File: rtl/te_trigger_top.sv
`timescale 1ns/1ps
module te_trigger_top
   import te_trig_pkg::*;
#(
   parameter int WIDTH_W     = 8,
   parameter int LINE_W      = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode,
   input  logic [WIDTH_W-1:0] hs_width,
   input  logic [WIDTH_W-1:0] vs_width,
   input  logic [LINE_W-1:0]  line_num,
   input  logic               hs_pol,
   input  logic               vs_pol,
   input  logic               te_in,
   input  logic               te_hs_in,
   input  logic               go,
   output logic               start,
   output logic               armed,
   output logic               cfg_err,
   output logic [LINE_W-1:0]  line_cnt
);

   if (WIDTH_W < 3) begin : g_bad_width
      $error("WIDTH_W must hold the minimum vertical width");
   end
   if (LINE_W < 1 || LINE_W > 16) begin : g_bad_line
      $error("LINE_W out of range");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES out of range");
   end

   trig_mode_e mode_e;
   logic internal;
   logic [NUM_TE_CHANNELS-1:0] ch_line;
   logic [NUM_TE_CHANNELS-1:0] ch_pol;
   logic [NUM_TE_CHANNELS-1:0] ch_end;
   logic [WIDTH_W-1:0]         ch_len [NUM_TE_CHANNELS];
   logic v_evt;
   logic h_evt;

   assign mode_e   = trig_mode_e'(mode);
   assign internal = (mode_e == TRIG_INTERNAL) || (mode_e == TRIG_RSVD);
   assign ch_line  = {te_hs_in, te_in};
   assign ch_pol   = {hs_pol, vs_pol};

   for (genvar c = 0; c < NUM_TE_CHANNELS; c++) begin : g_meter
      te_pulse_meter #(
         .WIDTH_W     (WIDTH_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_meter (
         .clk        (clk),
         .rst_n      (rst_n),
         .line_i     (ch_line[c]),
         .act_high_i (ch_pol[c]),
         .end_o      (ch_end[c]),
         .len_o      (ch_len[c])
      );
   end

   te_event_class #(
      .WIDTH_W (WIDTH_W)
   ) u_class (
      .mode_i     (mode_e),
      .hs_width_i (hs_width),
      .vs_width_i (vs_width),
      .a_end_i    (ch_end[0]),
      .a_len_i    (ch_len[0]),
      .b_end_i    (ch_end[1]),
      .b_len_i    (ch_len[1]),
      .v_evt_o    (v_evt),
      .h_evt_o    (h_evt),
      .cfg_err_o  (cfg_err)
   );

   te_line_tracker #(
      .LINE_W (LINE_W)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .internal_i (internal),
      .cfg_err_i  (cfg_err),
      .go_i       (go),
      .v_evt_i    (v_evt),
      .h_evt_i    (h_evt),
      .line_num_i (line_num),
      .start_o    (start),
      .armed_o    (armed),
      .line_cnt_o (line_cnt)
   );

   AST_INTERNAL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      internal |-> !cfg_err); // R4

endmodule

// File: tb/te_trigger_top_bench.sv
`timescale 1ns/1ps
module te_trigger_top_bench;

   localparam int GAP   = 10;
   localparam int HS_R  = 3;
   localparam int VS_R  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [7:0]  hs_width = 8'd3;
   logic [7:0]  vs_width = 8'd8;
   logic [10:0] line_num = 11'd0;
   logic        hs_pol = 1'b1;
   logic        vs_pol = 1'b1;
   logic        te_in = 1'b0;
   logic        te_hs_in = 1'b0;
   logic        go = 1'b0;
   logic        start;
   logic        armed;
   logic        cfg_err;
   logic [10:0] line_cnt;

   int n_checks = 0;
   int n_fail = 0;
   int n_start = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   te_trigger_top u_te_trigger_top (
      .clk(clk), .rst_n(rst_n), .mode(mode), .hs_width(hs_width), .vs_width(vs_width),
      .line_num(line_num), .hs_pol(hs_pol), .vs_pol(vs_pol), .te_in(te_in),
      .te_hs_in(te_hs_in), .go(go), .start(start), .armed(armed), .cfg_err(cfg_err),
      .line_cnt(line_cnt)
   );

   always @(negedge clk) if (rst_n && start) n_start++;

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse(input int ch, input int len);
      @(negedge clk);
      if (ch == 0) te_in = vs_pol; else te_hs_in = hs_pol;
      repeat (len) @(negedge clk);
      if (ch == 0) te_in = ~vs_pol; else te_hs_in = ~hs_pol;
      repeat (GAP) @(negedge clk);
   endtask

   task automatic pulse_both(input int len);
      @(negedge clk);
      te_in = vs_pol; te_hs_in = hs_pol;
      repeat (len) @(negedge clk);
      te_in = ~vs_pol; te_hs_in = ~hs_pol;
      repeat (GAP) @(negedge clk);
   endtask

   task automatic request();
      @(negedge clk); go = 1'b1;
      @(negedge clk); go = 1'b0;
   endtask

   function automatic int classify(input int len);
      if (len >= VS_R) return 2;
      if (len >= HS_R) return 1;
      return 0;
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int s0;
      int m_state;
      int m_cnt;
      int m_starts;
      int tgt;
      int ln;
      int ev;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 start", start, 0);
      chk("R1 armed", armed, 0);
      chk("R1 line_cnt", line_cnt, 0);

      // R2 internal modes
      mode = 2'd0;
      @(negedge clk); go = 1'b1;
      @(negedge clk); go = 1'b0;
      chk("R2 start after go", start, 1);
      chk("R2 armed", armed, 0);
      @(negedge clk);
      chk("R2 start one cycle", start, 0);
      mode = 2'd3;
      @(negedge clk); go = 1'b1;
      @(negedge clk);
      chk("R2 mode3 start", start, 1);
      @(negedge clk); go = 1'b0;
      chk("R2 go during start ignored", start, 0);
      chk("R2 mode3 armed", armed, 0);

      // R4 configuration rules
      mode = 2'd1; hs_width = 8'd1; vs_width = 8'd8; #1;
      chk("R4 hs too small", cfg_err, 1);
      request();
      @(negedge clk);
      chk("R4 go refused", armed, 0);
      hs_width = 8'd5; vs_width = 8'd5; #1; chk("R4 equal widths", cfg_err, 1);
      hs_width = 8'd2; vs_width = 8'd3; #1; chk("R4 mode1 vs below 4", cfg_err, 1);
      hs_width = 8'd6; vs_width = 8'd5; #1; chk("R4 mode1 vs below hs", cfg_err, 1);
      mode = 2'd2; hs_width = 8'd3; vs_width = 8'd2; #1; chk("R4 mode2 ok", cfg_err, 0);
      hs_width = 8'd2; vs_width = 8'd2; #1; chk("R4 mode2 equal", cfg_err, 1);
      mode = 2'd0; hs_width = 8'd1; #1; chk("R4 internal no err", cfg_err, 0);

      // R3/R6/R8/R9 shared line
      mode = 2'd1; hs_width = 8'd3; vs_width = 8'd8; line_num = 11'd2;
      @(negedge clk); chk("R4 valid", cfg_err, 0);
      s0 = n_start;
      request();
      chk("R3 armed", armed, 1);
      pulse(0, 4);
      chk("R8 h before v ignored", line_cnt, 0);
      pulse(0, 8);
      chk("R6 vertical at vs", line_cnt, 0);
      chk("R3 still armed", armed, 1);
      pulse(0, 7);
      chk("R6 horizontal at vs-1", line_cnt, 1);
      pulse(0, 2);
      chk("R6 short ignored", line_cnt, 1);
      chk("R3 no early start", n_start - s0, 0);
      pulse(0, 3);
      chk("R9 line reached", line_cnt, 2);
      chk("R9 start once", n_start - s0, 1);
      chk("R9 disarmed", armed, 0);
      pulse(0, 3);
      chk("R9 no second start", n_start - s0, 1);
      chk("R8 idle hold", line_cnt, 2);

      // R10 restart
      line_num = 11'd3; s0 = n_start;
      request();
      pulse(0, 8); pulse(0, 3); pulse(0, 3);
      chk("R10 count before restart", line_cnt, 2);
      pulse(0, 9);
      chk("R10 restart", line_cnt, 0);
      pulse(0, 3); pulse(0, 3);
      chk("R10 no start yet", n_start - s0, 0);
      pulse(0, 3);
      chk("R10 start after restart", n_start - s0, 1);

      // R11 go while armed
      line_num = 11'd2; s0 = n_start;
      request();
      pulse(0, 8); pulse(0, 3);
      request();
      @(negedge clk);
      chk("R11 armed kept", armed, 1);
      chk("R11 count kept", line_cnt, 1);
      pulse(0, 3);
      chk("R11 start", n_start - s0, 1);

      // R9 line zero
      line_num = 11'd0; s0 = n_start;
      request();
      pulse(0, 8);
      chk("R9 zero line start", n_start - s0, 1);
      chk("R9 zero line disarm", armed, 0);

      // R12 saturation
      line_num = 11'd1; s0 = n_start;
      request();
      pulse(0, 8);
      pulse(0, 260);
      chk("R12 long pulse is vertical", line_cnt, 0);
      chk("R12 still armed", armed, 1);
      pulse(0, 3);
      chk("R12 start", n_start - s0, 1);

      // R5/R7 split lines, active-low
      @(negedge clk);
      mode = 2'd2; hs_pol = 1'b0; vs_pol = 1'b0; te_in = 1'b1; te_hs_in = 1'b1;
      hs_width = 8'd3; vs_width = 8'd5; line_num = 11'd2;
      repeat (12) @(negedge clk);
      chk("R4 split valid", cfg_err, 0);
      s0 = n_start;
      request();
      pulse(1, 4);
      chk("R7 h before v ignored", line_cnt, 1);
      pulse(0, 4);
      chk("R7 short v ignored", line_cnt, 1);
      chk("R7 still armed", armed, 1);
      pulse(0, 5);
      chk("R5 active-low vertical", line_cnt, 0);
      pulse(1, 3);
      chk("R5 active-low horizontal", line_cnt, 1);
      pulse(1, 2);
      chk("R7 short h ignored", line_cnt, 1);
      pulse_both(6);
      chk("R7 coincident vertical only", line_cnt, 0);
      pulse(1, 9);
      chk("R7 long h is horizontal", line_cnt, 1);
      chk("R7 no start yet", n_start - s0, 0);
      pulse(1, 3);
      chk("R7 start", n_start - s0, 1);

      // random shared-line trains
      @(negedge clk);
      mode = 2'd1; hs_pol = 1'b1; vs_pol = 1'b1; te_in = 1'b0; te_hs_in = 1'b0;
      hs_width = 8'(HS_R); vs_width = 8'(VS_R);
      repeat (12) @(negedge clk);
      m_cnt = line_cnt;
      for (int it = 0; it < 20; it++) begin
         tgt = $urandom_range(0, 4);
         line_num = 11'(tgt);
         m_starts = n_start;
         request();
         m_state = 1;
         for (int p = 0; p < 40; p++) begin
            if (m_state == 0) break;
            if (p < 12) ln = $urandom_range(1, 12);
            else ln = (m_state == 1) ? VS_R : HS_R;
            pulse(0, ln);
            ev = classify(ln);
            if (ev == 2) begin
               m_cnt = 0;
               if (tgt == 0) begin m_state = 0; m_starts++; end
               else m_state = 2;
            end else if (ev == 1 && m_state == 2) begin
               m_cnt++;
               if (m_cnt == tgt) begin m_state = 0; m_starts++; end
            end
            chk("R8 random line_cnt", line_cnt, m_cnt);
            chk("R9 random starts", n_start, m_starts);
            chk("R3 random armed", armed, (m_state != 0) ? 1 : 0);
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule